// File: doc/BRIEF.md
# Calendar Shadow-Register Synchronizer

This block keeps a running sub-second, time and date count in the RTC clock domain. It also keeps a copy of those values that bus-domain logic reads. Every second RTC clock edge, the live count is captured into a holding register. A toggle crosses to the bus domain through a multi-flop synchronizer, and the bus side then loads its shadow registers and raises a sync flag. Software clears the flag by writing zero, and the next completed copy sets it again. A bypass input makes the read outputs show the live counters instead of the shadows.

Software can move the clock one hour forward or back with a single command. No initialization sequence is needed. The command is raised in the bus domain, crosses to the RTC domain through a toggle synchronizer, and is applied on one RTC edge. A separate backup bit can be written to record that a daylight-saving change was made. Shadow reads are only reliable when the bus clock runs at least seven times the RTC clock. The bus clock must never be slower than the RTC clock.

Top module: `cal_shadow_sync`

## Requirements
- R1: After reset, every RTC edge advances the count as follows:
  - The sub-second field increments and wraps from SUB_DIV-1 to 0, carrying into seconds.
  - Seconds wrap at SEC_PER_MIN-1 into minutes.
  - Minutes wrap at MIN_PER_HOUR-1 into the hour.
  - The hour wraps from 23 to 0 and increments the date, which counts modulo 2^DAY_W.
- R2: time_o carries {hour[4:0], minute, second} from MSB to LSB. subsec_o carries the sub-second field and date_o carries the day count.
- R3: Each even-numbered RTC edge after reset (2nd, 4th, ...) captures the live value held just before that edge. With the bus clock at least seven times the RTC clock, that value is in the shadow registers by the middle of the next RTC period. It stays there until the next capture.
- R4: sync_o rises in the bus cycle in which the shadow registers load.
- R5: A one-cycle sync_clr_i pulse clears sync_o, and sync_o stays low until the next shadow load. If a load and a clear fall in the same bus cycle, the load wins.
- R6: While bypass_i is high, subsec_o, time_o and date_o show the live RTC-domain counters. While it is low, they show the shadows.
- R7: A one-cycle add_hour_i pulse adds one hour on the (SYNC_STAGES+1)th RTC edge after the bus edge that samples it. The step is added on top of any carry from the minutes on that same edge. Going past 23 wraps the hour and increments the date.
- R8: A one-cycle sub_hour_i pulse subtracts one hour on the same edge as in R7. It is ignored when the hour just before that edge is 0.
- R9: If add_hour_i and sub_hour_i are both high in the same bus cycle, only the add takes effect.
- R10: bkp_wr_i high loads bkp_d_i into bkp_o. Otherwise bkp_o holds, and hour commands do not change it.
- R11: During reset, sync_o, bkp_o and all read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rtc_clk_i | input | 1 | RTC clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bypass_i | input | 1 | Read live counters instead of shadows |
| sync_clr_i | input | 1 | Clear sync flag (software writes zero) |
| add_hour_i | input | 1 | Add-one-hour command pulse |
| sub_hour_i | input | 1 | Subtract-one-hour command pulse |
| bkp_wr_i | input | 1 | Backup bit write strobe |
| bkp_d_i | input | 1 | Backup bit write data |
| subsec_o | output | SUB_W | Sub-second read value |
| time_o | output | 5+MIN_W+SEC_W | Hour, minute, second read value |
| date_o | output | DAY_W | Day count read value |
| sync_o | output | 1 | Shadow copy completed flag |
| bkp_o | output | 1 | Backup bit |

## Verification
The bench uses a small calendar (four sub-seconds, four seconds, four minutes) and a bus clock eight times the RTC clock. It runs across several simulated days, and at every RTC mid-period it reads the outputs twice: once through the shadows and once through bypass. The shadow read must match the value before the last even edge. It therefore tells a correct two-edge capture apart from a copy that is one edge early, one edge late, or taken on every edge.

Hour commands are issued at hours 4, 6 and 8, one step before a day rollover, and at hour 0. These cases separate:
- plain adds and subtracts;
- add priority over subtract;
- an add that lands on the same edge as a minute carry;
- a subtract that must be ignored.

The sync flag is cleared before an odd edge, before an even edge, and in the exact bus cycle of a load. This confirms that the flag is set only by a finished copy and that set wins over clear.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  localparam int unsigned HOURS_PER_DAY = 24;
  localparam int unsigned HOUR_W = 5;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADD  = 2'd1,
    ADJ_SUB  = 2'd2
  } adj_cmd_e;
endpackage

// File: rtl/cal_toggle_sync.sv
module cal_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] chain;
  logic last_q;

  assign chain[0] = tgl_i;

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= 1'b0;
      else         chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain[STAGES];
  end

  assign pulse_o = chain[STAGES] ^ last_q;
endmodule

// File: rtl/cal_rtc_counter.sv
module cal_rtc_counter
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SUB_DIV      = 256,
  parameter int unsigned SEC_PER_MIN  = 60,
  parameter int unsigned MIN_PER_HOUR = 60,
  parameter int unsigned DAY_W        = 16,
  localparam int unsigned SUB_W = $clog2(SUB_DIV),
  localparam int unsigned SEC_W = $clog2(SEC_PER_MIN),
  localparam int unsigned MIN_W = $clog2(MIN_PER_HOUR),
  localparam int unsigned CAL_W = DAY_W + HOUR_W + MIN_W + SEC_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  adj_cmd_e         adj_i,
  output logic [CAL_W-1:0] live_o,
  output logic [CAL_W-1:0] hold_o,
  output logic             req_o
);
  logic [SUB_W-1:0]  sub_q;
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q, hour_d;
  logic [DAY_W-1:0]  day_q;
  logic [HOUR_W:0]   hour_sum;
  logic sub_wrap, sec_wrap, min_wrap, day_carry;
  logic ph_q, req_q;
  logic [CAL_W-1:0] hold_q;

  assign sub_wrap = (sub_q == SUB_W'(SUB_DIV - 1));
  assign sec_wrap = sub_wrap && (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign min_wrap = sec_wrap && (min_q == MIN_W'(MIN_PER_HOUR - 1));

  // carry and hour command combine in one step
  always_comb begin
    hour_sum = {1'b0, hour_q} + {{HOUR_W{1'b0}}, min_wrap};
    case (adj_i)
      ADJ_ADD: hour_sum = hour_sum + (HOUR_W+1)'(1);
      ADJ_SUB: if (hour_q != '0) hour_sum = hour_sum - (HOUR_W+1)'(1);
      default: ;
    endcase
    day_carry = (hour_sum >= (HOUR_W+1)'(HOURS_PER_DAY));
    hour_d = day_carry ? HOUR_W'(hour_sum - (HOUR_W+1)'(HOURS_PER_DAY))
                       : hour_sum[HOUR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else begin
      sub_q <= sub_wrap ? '0 : sub_q + SUB_W'(1);
      if (sub_wrap) sec_q <= sec_wrap ? '0 : sec_q + SEC_W'(1);
      if (sec_wrap) min_q <= min_wrap ? '0 : min_q + MIN_W'(1);
      hour_q <= hour_d;
      if (day_carry) day_q <= day_q + DAY_W'(1);
    end
  end

  assign live_o = {day_q, hour_q, min_q, sec_q, sub_q};

  // capture every second edge, announce with a toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        hold_q <= live_o;
        req_q  <= ~req_q;
      end
    end
  end

  assign hold_o = hold_q;
  assign req_o  = req_q;

  // R1
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_wrap |=> $stable(sec_q));
  // R3
  capture_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q |=> req_q != $past(req_q));
  // R3
  capture_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_q |=> $stable(req_q) && $stable(hold_q));
  // R7
  add_rollover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_i == ADJ_ADD && hour_q == HOUR_W'(23))
      |=> (hour_q <= HOUR_W'(1)) && (day_q == $past(day_q) + DAY_W'(1)));
  // R8
  sub_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_i == ADJ_SUB && hour_q == '0 && !min_wrap)
      |=> hour_q == '0 && $stable(day_q));
endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic [W-1:0] shadow_o,
  output logic         sync_o
);
  logic [W-1:0] shadow_q;
  logic         sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      sync_q   <= 1'b0;
    end else begin
      if (load_i) shadow_q <= data_i;
      if (load_i)     sync_q <= 1'b1;
      else if (clr_i) sync_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign sync_o   = sync_q;

  // R3
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_q));
  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sync_q);
  // R5
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !sync_q);
  // R5
  flag_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_q && !load_i) |=> !sync_q);
endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SUB_DIV      = 256,
  parameter int unsigned SEC_PER_MIN  = 60,
  parameter int unsigned MIN_PER_HOUR = 60,
  parameter int unsigned DAY_W        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned SUB_W  = $clog2(SUB_DIV),
  localparam int unsigned SEC_W  = $clog2(SEC_PER_MIN),
  localparam int unsigned MIN_W  = $clog2(MIN_PER_HOUR),
  localparam int unsigned TIME_W = HOUR_W + MIN_W + SEC_W,
  localparam int unsigned CAL_W  = DAY_W + TIME_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rtc_clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              sync_clr_i,
  input  logic              add_hour_i,
  input  logic              sub_hour_i,
  input  logic              bkp_wr_i,
  input  logic              bkp_d_i,
  output logic [SUB_W-1:0]  subsec_o,
  output logic [TIME_W-1:0] time_o,
  output logic [DAY_W-1:0]  date_o,
  output logic              sync_o,
  output logic              bkp_o
);
  logic add_tgl_q, sub_tgl_q, bkp_q;
  logic add_p, sub_p, load_p, req_t;
  adj_cmd_e adj;
  logic [CAL_W-1:0] live, hold, shadow, view;

  // bus side: commands self-clear, only a toggle persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_tgl_q <= 1'b0;
      sub_tgl_q <= 1'b0;
      bkp_q     <= 1'b0;
    end else begin
      if (add_hour_i)      add_tgl_q <= ~add_tgl_q;
      else if (sub_hour_i) sub_tgl_q <= ~sub_tgl_q;
      if (bkp_wr_i) bkp_q <= bkp_d_i;
    end
  end

  cal_toggle_sync #(.STAGES(SYNC_STAGES)) u_add_sync (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .tgl_i(add_tgl_q), .pulse_o(add_p));

  cal_toggle_sync #(.STAGES(SYNC_STAGES)) u_sub_sync (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .tgl_i(sub_tgl_q), .pulse_o(sub_p));

  assign adj = add_p ? ADJ_ADD : (sub_p ? ADJ_SUB : ADJ_NONE);

  cal_rtc_counter #(
    .SUB_DIV(SUB_DIV), .SEC_PER_MIN(SEC_PER_MIN),
    .MIN_PER_HOUR(MIN_PER_HOUR), .DAY_W(DAY_W)
  ) u_counter (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .adj_i(adj),
    .live_o(live), .hold_o(hold), .req_o(req_t));

  cal_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .tgl_i(req_t), .pulse_o(load_p));

  cal_shadow_bank #(.W(CAL_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_p), .data_i(hold),
    .clr_i(sync_clr_i), .shadow_o(shadow), .sync_o(sync_o));

  assign view     = bypass_i ? live : shadow;
  assign subsec_o = view[SUB_W-1:0];
  assign time_o   = view[SUB_W +: TIME_W];
  assign date_o   = view[CAL_W-1 -: DAY_W];
  assign bkp_o    = bkp_q;

  // R9
  add_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_hour_i && sub_hour_i) |=> $stable(sub_tgl_q));
  // R10
  bkp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bkp_wr_i |=> $stable(bkp_o));
endmodule

// File: tb/cal_shadow_sync_test.sv
module cal_shadow_sync_test;
  localparam int SUBD = 4, SECN = 4, MINN = 4, DAYW = 4, STG = 2;
  localparam int TPH = SUBD * SECN * MINN;
  localparam int LAT = STG + 1;

  logic clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
  logic bypass = 1'b0, sync_clr = 1'b0, add_h = 1'b0, sub_h = 1'b0;
  logic bkp_wr = 1'b0, bkp_d = 1'b0;
  logic [1:0] subsec_o;
  logic [8:0] time_o;
  logic [3:0] date_o;
  logic sync_o, bkp_o;

  int vectors = 0, errors = 0;
  int mw = 0, mh = 0, n = 0, pw1 = 0, ph1 = 0, pw2 = 0, ph2 = 0;
  int add_at = -1, sub_at = -1;

  always #2 clk = ~clk;
  always #16 rtc_clk = ~rtc_clk;

  cal_shadow_sync #(.SUB_DIV(SUBD), .SEC_PER_MIN(SECN), .MIN_PER_HOUR(MINN),
                    .DAY_W(DAYW), .SYNC_STAGES(STG)) uut (
    .clk_i(clk), .rtc_clk_i(rtc_clk), .rst_ni(rst_n), .bypass_i(bypass),
    .sync_clr_i(sync_clr), .add_hour_i(add_h), .sub_hour_i(sub_h),
    .bkp_wr_i(bkp_wr), .bkp_d_i(bkp_d), .subsec_o(subsec_o), .time_o(time_o),
    .date_o(date_o), .sync_o(sync_o), .bkp_o(bkp_o));

  // reference calendar: w = ticks within hour, h = absolute hours
  always @(posedge rtc_clk) if (rst_n) begin
    int hb;
    hb = mh % 24;
    pw2 = pw1; ph2 = ph1; pw1 = mw; ph1 = mh;
    mw = mw + 1;
    if (mw == TPH) begin mw = 0; mh = mh + 1; end
    n = n + 1;
    if (add_at == n) begin mh = mh + 1; add_at = -1; end
    if (sub_at == n) begin if (hb != 0) mh = mh - 1; sub_at = -1; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input int w, input int h);
    int et;
    et = (h % 24) * 16 + (w / (SUBD * SECN)) * 4 + (w / SUBD) % SECN;
    chk({tag, " subsec"}, int'(subsec_o), w % SUBD);
    chk({tag, "/R2 time"}, int'(time_o), et);
    chk({tag, " date"}, int'(date_o), (h / 24) % 16);
  endtask

  task automatic shadow_cmp(input string tag);
    if (n % 2 == 0) cmp(tag, pw1, ph1);
    else            cmp(tag, pw2, ph2);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    bit did_a, did_s, did_b, did_w, did_z;
    int win;
    string wtag;
    did_a = 0; did_s = 0; did_b = 0; did_w = 0; did_z = 0;
    win = 100; wtag = "R6";
    #90;
    // R11 reset state
    chk("R11 sync", int'(sync_o), 0);
    chk("R11 bkp", int'(bkp_o), 0);
    cmp("R11", 0, 0);
    #6 rst_n = 1'b1;   // released at t=96, an RTC mid-period

    // R4 / R5 flag behaviour
    do @(negedge rtc_clk); while (n < 4 || n % 2 != 0);
    chk("R4 set after copy", int'(sync_o), 1);
    shadow_cmp("R3");
    sync_clr = 1'b1; #4 sync_clr = 1'b0; #2;
    chk("R5 cleared", int'(sync_o), 0);
    @(negedge rtc_clk);
    chk("R5 no set on odd edge", int'(sync_o), 0);
    @(negedge rtc_clk);
    chk("R4 set on next copy", int'(sync_o), 1);
    sync_clr = 1'b1; #4 sync_clr = 1'b0;
    @(negedge rtc_clk);
    chk("R5 stays clear", int'(sync_o), 0);
    #24 sync_clr = 1'b1; #4 sync_clr = 1'b0; #2;
    chk("R5 load beats clear", int'(sync_o), 1);

    // R10 backup bit
    @(negedge rtc_clk);
    bkp_d = 1'b1; bkp_wr = 1'b1; #4 bkp_wr = 1'b0; bkp_d = 1'b0; #2;
    chk("R10 written one", int'(bkp_o), 1);
    @(negedge rtc_clk);
    chk("R10 holds without strobe", int'(bkp_o), 1);

    // calendar sweep with hour commands
    for (int i = 0; i < 3600; i++) begin
      @(negedge rtc_clk);
      if (!did_a && mh % 24 == 4 && mw == 10) begin
        did_a = 1; add_h = 1'b1; add_at = n + LAT; win = 0; wtag = "R7";
      end else if (did_a && !did_s && mh % 24 == 6 && mw == 10) begin
        did_s = 1; sub_h = 1'b1; sub_at = n + LAT; win = 0; wtag = "R8";
      end else if (did_s && !did_b && mh % 24 == 8 && mw == 10) begin
        did_b = 1; add_h = 1'b1; sub_h = 1'b1; add_at = n + LAT; win = 0; wtag = "R9";
      end else if (did_b && !did_w && mh % 24 == 23 && mw == TPH - 3) begin
        did_w = 1; add_h = 1'b1; add_at = n + LAT; win = 0; wtag = "R7";
      end else if (did_w && !did_z && mh >= 24 && mh % 24 == 0 && mw == 20) begin
        did_z = 1; sub_h = 1'b1; sub_at = n + LAT; win = 0; wtag = "R8";
      end
      bypass = 1'b0; #1;
      shadow_cmp("R3");
      bypass = 1'b1; #1;
      cmp((win < 8) ? wtag : "R1", mw, mh);
      win++;
      #2 add_h = 1'b0; sub_h = 1'b0; bypass = 1'b0;
    end
    chk("R7 all commands issued", int'(did_z), 1);
    chk("R10 untouched by hour commands", int'(bkp_o), 1);
    @(negedge rtc_clk);
    bkp_wr = 1'b1; #4 bkp_wr = 1'b0; #2;
    chk("R10 written zero", int'(bkp_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule